// File: doc/BRIEF.md
# Switch-Addressed Digital I/O Port Controller

This block is the logic core of an 8-bit I/O-mapped digital I/O card on the ISA bus. It compares the upper I/O address bits with a base address set on board switches. It responds only while the address-enable line is low. Once selected, it decodes the two lowest address bits into three readable ports and one writable port:

- Two readable ports return the sixteen isolated digital inputs, one byte per port.
- The third readable port returns the relay output latch.
- The writable port loads that same latch, so software writes and reads back the relays at one address.

The relay controls are active-low. They stay released (high impedance) after reset until software first writes the output port.

All internal logic runs on one system clock. The bus strobes and the sixteen inputs are synchronised before use. The data bus and the ready line are modelled as separate drive and enable signals, so the card can place its own tri-state and open-drain pads around the block. For every selected access the ready line is held low for a fixed number of clocks. This gives the synchronised read data time to settle.

Top module: `isa_dio_port`

## Requirements
- R1: The card is selected only while `aenN` is 0 and `sa[9:2]` equals `baseSw`. When it is not selected, an access drives no data (`sdOe` stays 0), never pulls `ioRdyLow`, and leaves the output latch unchanged.
- R2: With the card selected, `sa[1:0]`=0 reads `inBits[7:0]`, 1 reads `inBits[15:8]` and 2 reads the output latch. Index 3 gives no response: no data drive and no ready pull.
- R3: A write to index 2 loads `sdIn` into the output latch when `iowN` rises. A later read at the same index returns that byte.
- R4: `sdOe` is 1 only while `iorN` is 0 during a selected read of index 0, 1 or 2. It returns to 0 as soon as `iorN` goes high.
- R5: `relayN[i]` equals latch bit i. A 0 closes relay i and lights its indicator; a 1 opens it.
- R6: `relayOe` is 0 from reset until the first completed write to index 2. After that it stays 1 until the next reset.
- R7: The inputs pass through two synchronising flip-flops. They are sampled once, on the falling edge of `iorN`. An input change after that sample does not change the byte returned by the read in progress.
- R8: Each selected access holds `ioRdyLow` at 1 for exactly 2 clock cycles, starting within 3 cycles of the strobe falling.
- R9: While `rst` is 1 and right after it, the latch reads 0xFF, `relayN` is 0xFF, and `relayOe`, `sdOe` and `ioRdyLow` are 0.
- R10: Writes with the card selected to index 0, 1 or 3 leave the output latch and `relayOe` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Bus reset, active high |
| aenN | input | 1 | Address enable, active low |
| sa | input | 10 | I/O address |
| iorN | input | 1 | I/O read strobe, active low |
| iowN | input | 1 | I/O write strobe, active low |
| baseSw | input | 8 | Switch-set base address for sa[9:2] |
| sdIn | input | 8 | Data bus value seen by the block |
| sdOut | output | 8 | Data the block drives on reads |
| sdOe | output | 1 | Enables the data bus drivers |
| ioRdyLow | output | 1 | 1 pulls the open-drain ready line low |
| inBits | input | 16 | Isolated digital inputs (logic level) |
| relayN | output | 8 | Active-low relay and indicator controls |
| relayOe | output | 1 | Enables the relay control drivers |

## Verification
Reads use input patterns with opposite halves, such as 0xA55A and 0x0FF0. These show whether index 0 and index 1 return the correct bytes or return them swapped. Latch values 0x3C, 0x00 and 0xFF are written and read back at the same index. This separates the readback path from the input path and checks that `relayN` follows the latch bit for bit.

Several accesses are made that must have no effect: a mismatched base address, `aenN` high, index 3, and writes to the read-only indices. Each is followed by a read that would expose any stray change. Finally, the inputs are changed in the middle of a read, to show that the sample is taken at the strobe edge and not at its end.

// File: rtl/isa_dio_pkg.sv
package isa_dio_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic       rdStart;   // sample read data this cycle
    logic [1:0] rdPort;    // which port to sample
    logic       wrHold;    // capture bus data this cycle
    logic       wrCommit;  // move captured data into latch
  } ctrlStrobes_t;
endpackage

// File: rtl/isa_dio_ctrl.sv
module isa_dio_ctrl
  import isa_dio_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int RDY_CYCLES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                aenN,
  input  logic [ADDR_W-1:0]   sa,
  input  logic                iorN,
  input  logic                iowN,
  input  logic [ADDR_W-3:0]   baseSw,
  output logic                sdOe,
  output logic                ioRdyLow,
  output ctrlStrobes_t        strb
);
  localparam int CNT_W = $clog2(RDY_CYCLES + 1);

  logic [2:0] iorSh, iowSh;
  logic       boardSel, rdHit, wrHit;
  logic       iorFall, iowFall, iowRise;
  logic       wrPend;
  logic [CNT_W-1:0] rdyCnt;

  assign boardSel = !aenN && (sa[ADDR_W-1:2] == baseSw);
  assign rdHit    = boardSel && (sa[1:0] != 2'd3);
  assign wrHit    = boardSel && (sa[1:0] == 2'd2);

  assign iorFall = !iorSh[1] && iorSh[2];
  assign iowFall = !iowSh[1] && iowSh[2];
  assign iowRise = iowSh[1] && !iowSh[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      iorSh <= '1;
      iowSh <= '1;
    end else begin
      iorSh <= {iorSh[1:0], iorN};
      iowSh <= {iowSh[1:0], iowN};
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                  wrPend <= 1'b0;
    else if (iowFall && wrHit) wrPend <= 1'b1;
    else if (iowRise)         wrPend <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdyCnt <= '0;
    else if ((iorFall && rdHit) || (iowFall && wrHit))
      rdyCnt <= CNT_W'(RDY_CYCLES);
    else if (rdyCnt != '0)
      rdyCnt <= rdyCnt - 1'b1;
  end

  assign ioRdyLow = (rdyCnt != '0);
  assign sdOe     = !iorN && rdHit;

  always_comb begin
    strb.rdStart  = iorFall && rdHit;
    strb.rdPort   = sa[1:0];
    strb.wrHold   = !iowSh[1] && wrHit;
    strb.wrCommit = iowRise && wrPend;
  end
endmodule

// File: rtl/isa_dio_dpath.sv
module isa_dio_dpath
  import isa_dio_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  ctrlStrobes_t         strb,
  input  logic [DATA_W-1:0]    sdIn,
  input  logic [2*DATA_W-1:0]  inBits,
  output logic [DATA_W-1:0]    sdOut,
  output logic [DATA_W-1:0]    relayN,
  output logic                 relayOe
);
  localparam int IN_W = 2 * DATA_W;

  logic [IN_W-1:0]   inPipe [SYNC_STAGES];
  logic [DATA_W-1:0] rdData, wrData, outLatch;

  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk) begin
        if (rst) inPipe[s] <= '0;
        else if (s == 0) inPipe[s] <= inBits;
        else inPipe[s] <= inPipe[(s == 0) ? 0 : s - 1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rdData <= '0;
    end else if (strb.rdStart) begin
      unique case (strb.rdPort)
        2'd0:    rdData <= inPipe[SYNC_STAGES-1][DATA_W-1:0];
        2'd1:    rdData <= inPipe[SYNC_STAGES-1][IN_W-1:DATA_W];
        default: rdData <= outLatch;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrData   <= '1;
      outLatch <= '1;
      relayOe  <= 1'b0;
    end else begin
      if (strb.wrHold) wrData <= sdIn;
      if (strb.wrCommit) begin
        outLatch <= wrData;
        relayOe  <= 1'b1;
      end
    end
  end

  assign sdOut  = rdData;
  assign relayN = outLatch;
endmodule

// File: rtl/isa_dio_port.sv
module isa_dio_port
  import isa_dio_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 8,
  parameter int RDY_CYCLES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                aenN,
  input  logic [ADDR_W-1:0]   sa,
  input  logic                iorN,
  input  logic                iowN,
  input  logic [ADDR_W-3:0]   baseSw,
  input  logic [DATA_W-1:0]   sdIn,
  output logic [DATA_W-1:0]   sdOut,
  output logic                sdOe,
  output logic                ioRdyLow,
  input  logic [2*DATA_W-1:0] inBits,
  output logic [DATA_W-1:0]   relayN,
  output logic                relayOe
);
  ctrlStrobes_t strb;

  isa_dio_ctrl #(.ADDR_W(ADDR_W), .RDY_CYCLES(RDY_CYCLES)) u_ctrl (
    .clk(clk), .rst(rst), .aenN(aenN), .sa(sa), .iorN(iorN), .iowN(iowN),
    .baseSw(baseSw), .sdOe(sdOe), .ioRdyLow(ioRdyLow), .strb(strb)
  );

  isa_dio_dpath #(.DATA_W(DATA_W), .SYNC_STAGES(2)) u_dpath (
    .clk(clk), .rst(rst), .strb(strb), .sdIn(sdIn), .inBits(inBits),
    .sdOut(sdOut), .relayN(relayN), .relayOe(relayOe)
  );
endmodule

// File: rtl/isa_dio_port_chk.sv
module isa_dio_port_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              aenN,
  input logic              iorN,
  input logic              iowN,
  input logic              ioRdyLow,
  input logic [DATA_W-1:0] relayN,
  input logic              relayOe
);
  // R1: ready is pulled only for an access made with address enable low
  p_rdy_needs_aen_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(ioRdyLow) |-> !$past(aenN));

  // R8: ready is pulled only while a strobe is active, and for at least 2 cycles
  p_rdy_has_strobe_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(ioRdyLow) |-> $past(!iorN || !iowN));
  p_rdy_two_cycles_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(ioRdyLow) |=> ioRdyLow);

  // R6: once enabled, the relay drivers stay enabled
  p_relay_oe_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    relayOe |=> relayOe);

  // R5: relay controls never change while their drivers are off
  p_relay_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(relayN) |-> relayOe);

  // R9: the cycle after reset shows the power-up state
  p_reset_state_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (relayN == '1 && !relayOe && !ioRdyLow));
endmodule

bind isa_dio_port isa_dio_port_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/isa_dio_port_tb.sv
module isa_dio_port_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        aenN = 1'b1;
  logic [9:0]  sa = '0;
  logic        iorN = 1'b1;
  logic        iowN = 1'b1;
  logic [7:0]  baseSw = 8'h64;
  logic [7:0]  sdIn = '0;
  logic [7:0]  sdOut;
  logic        sdOe;
  logic        ioRdyLow;
  logic [15:0] inBits = '0;
  logic [7:0]  relayN;
  logic        relayOe;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  isa_dio_port u_dut (
    .clk(clk), .rst(rst), .aenN(aenN), .sa(sa), .iorN(iorN), .iowN(iowN),
    .baseSw(baseSw), .sdIn(sdIn), .sdOut(sdOut), .sdOe(sdOe),
    .ioRdyLow(ioRdyLow), .inBits(inBits), .relayN(relayN), .relayOe(relayOe)
  );

  localparam logic [9:0] BASE = 10'h190;

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  // Bus read: returns the data, number of ready-low cycles, and whether the bus was driven
  task automatic busRead(input logic [9:0] addr, input logic aen,
                         output logic [7:0] data, output int rdy, output logic oe,
                         input bit midChange = 0, input logic [15:0] newIn = '0);
    rdy = 0; oe = 0;
    @(negedge clk); sa = addr; aenN = aen;
    @(negedge clk); iorN = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (ioRdyLow) rdy++;
      if (sdOe) oe = 1;
      if (midChange && i == 3) inBits = newIn;
    end
    data = sdOut;
    iorN = 1'b0;
    @(negedge clk); iorN = 1'b1;
    #1;
    if (sdOe) oe = 1'bx;   // still driving after strobe release
    repeat (4) @(negedge clk);
    aenN = 1'b1;
  endtask

  task automatic busWrite(input logic [9:0] addr, input logic aen,
                          input logic [7:0] data, output int rdy);
    rdy = 0;
    @(negedge clk); sa = addr; aenN = aen; sdIn = data;
    @(negedge clk); iowN = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (ioRdyLow) rdy++;
    end
    iowN = 1'b1;
    repeat (5) @(negedge clk);
    aenN = 1'b1;
    sdIn = 8'h00;
  endtask

  task automatic testReset();
    chk("R9", "relayN at reset", {8'h0, relayN}, 16'h00FF);
    chk("R9", "relayOe at reset", {15'h0, relayOe}, 16'h0);
    chk("R9", "sdOe at reset", {15'h0, sdOe}, 16'h0);
    chk("R9", "ioRdyLow at reset", {15'h0, ioRdyLow}, 16'h0);
  endtask

  task automatic testReadPorts(input logic [15:0] pat);
    logic [7:0] d; int r; logic oe;
    inBits = pat;
    repeat (4) @(negedge clk);
    busRead(BASE + 0, 1'b0, d, r, oe);
    chk("R2", "low input byte", {8'h0, d}, {8'h0, pat[7:0]});
    chk("R8", "ready cycles on read", 16'(r), 16'd2);
    chk("R4", "bus driven on read", {15'h0, oe}, 16'h1);
    busRead(BASE + 1, 1'b0, d, r, oe);
    chk("R2", "high input byte", {8'h0, d}, {8'h0, pat[15:8]});
  endtask

  task automatic testWriteReadback(input logic [7:0] val);
    logic [7:0] d; int r; logic oe;
    busWrite(BASE + 2, 1'b0, val, r);
    chk("R8", "ready cycles on write", 16'(r), 16'd2);
    chk("R5", "relay outputs follow latch", {8'h0, relayN}, {8'h0, val});
    chk("R6", "relay drivers enabled", {15'h0, relayOe}, 16'h1);
    busRead(BASE + 2, 1'b0, d, r, oe);
    chk("R3", "readback at write address", {8'h0, d}, {8'h0, val});
  endtask

  task automatic testUnselected();
    logic [7:0] d; int r; logic oe;
    busRead(10'h194, 1'b0, d, r, oe);
    chk("R1", "no drive on other base", {15'h0, oe}, 16'h0);
    chk("R1", "no ready on other base", 16'(r), 16'd0);
    busRead(BASE + 0, 1'b1, d, r, oe);
    chk("R1", "no drive with aen high", {15'h0, oe}, 16'h0);
    chk("R1", "no ready with aen high", 16'(r), 16'd0);
    busRead(BASE + 3, 1'b0, d, r, oe);
    chk("R2", "index 3 not driven", {15'h0, oe}, 16'h0);
    chk("R2", "index 3 no ready", 16'(r), 16'd0);
    busWrite(10'h18E, 1'b0, 8'h11, r);
    chk("R1", "other-base write ignored", {8'h0, relayN}, 16'h003C);
    busWrite(BASE + 2, 1'b1, 8'h22, r);
    chk("R1", "aen-high write ignored", {8'h0, relayN}, 16'h003C);
  endtask

  task automatic testReadOnlyWrites();
    logic [7:0] d; int r; logic oe;
    busWrite(BASE + 0, 1'b0, 8'h81, r);
    busWrite(BASE + 1, 1'b0, 8'h42, r);
    busWrite(BASE + 3, 1'b0, 8'h24, r);
    chk("R10", "latch after read-only writes", {8'h0, relayN}, 16'h003C);
    busRead(BASE + 2, 1'b0, d, r, oe);
    chk("R10", "readback after read-only writes", {8'h0, d}, 16'h003C);
  endtask

  task automatic testMidReadChange();
    logic [7:0] d; int r; logic oe;
    inBits = 16'h1234;
    repeat (4) @(negedge clk);
    busRead(BASE + 0, 1'b0, d, r, oe, 1'b1, 16'hEDCB);
    chk("R7", "value held from strobe edge", {8'h0, d}, 16'h0034);
    repeat (4) @(negedge clk);
    busRead(BASE + 0, 1'b0, d, r, oe);
    chk("R7", "new value on next read", {8'h0, d}, 16'h00CB);
  endtask

  task automatic testRelayOffBeforeWrite();
    chk("R6", "drivers off before first write", {15'h0, relayOe}, 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rst = 1'b0;
    @(negedge clk);
    testReset();
    testReadPorts(16'hA55A);
    testRelayOffBeforeWrite();
    testReadPorts(16'h0FF0);
    testWriteReadback(8'h00);
    testWriteReadback(8'hFF);
    testWriteReadback(8'h3C);
    testUnselected();
    testReadOnlyWrites();
    testMidReadChange();
    // reset again restores the power-up state
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    rst = 1'b0;
    @(negedge clk);
    testReset();
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end
endmodule